// File: doc/BRIEF.md
# Banked Pad Control Register File

This block holds the pad settings for one power domain's worth of general-purpose pins. The pins are grouped into banks, and each bank is a contiguous range of pin numbers. There are five register ranges. Four of them can be written: pull enable, pull polarity, direction and output level. The fifth is a read-only view of the pad inputs after they pass through a synchronizer. In every range, a bank occupies a run of consecutive bits. Where that run starts (which word, which bit) is set per bank by parameters, so one 32-bit word can hold pieces of several banks.

Each pin drives four pad signals: an output enable, an output level, a pull-up enable and a pull-down enable. Software reaches the registers through a simple word-addressed bus. A write carries a byte strobe, so a bank can be updated without disturbing another bank that shares the same word. A build option moves the pull-enable bits into the pull-polarity range. In that build the pull-enable range does not exist on the bus.

Top module: `gpb_regfile`

## Requirements
- R1: After reset, every pin is an input (pad_oe low), bias is off (pad_pu and pad_pd low), and every output level bit is 0.
- R2: The bus word address is {range[2:0], word}. The range codes are 0 pull enable, 1 pull polarity, 2 direction, 3 output level and 4 input. Pin p of bank b sits in word REG[b] of each range, at bit BIT[b] + p − BANK_FIRST[b]. The byte offset of a word is its index times 4.
- R3: A direction bit of 1 makes the pin an input (pad_oe=0). A direction bit of 0 makes it an output (pad_oe=1).
- R4: With the pull-enable bit at 0, both pad_pu and pad_pd are low. With it at 1, a polarity bit of 1 raises pad_pu only, and a polarity bit of 0 raises pad_pd only.
- R5: pad_out follows the pin's output level bit.
- R6: The input range returns each pad input after a two-flop synchronizer. Writes to the input range change nothing.
- R7: A write updates only the bytes whose strobe bit is set. Bits of other banks in the same word keep their values.
- R8: Bits that belong to no pin read as 0, and writing them has no effect.
- R9: These accesses report bus_err=1, return bus_rdata=0 and change no state: a word that holds no pin bit, a range code of 5 to 7, or range 0 when PULL_ALIAS=1.
- R10: With PULL_ALIAS=1, the pull-enable bits sit in the pull-polarity range at the pull-enable word and bit positions.
- R11: bus_rvalid, bus_rdata and bus_err are registered. They appear one cycle after the access is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write request |
| bus_re | input | 1 | Read request |
| bus_addr | input | 3+WIDX_W | Word address {range, word} |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte strobes for the write |
| bus_rdata | output | 32 | Read data, 0 on writes and errors |
| bus_rvalid | output | 1 | Response marker, one cycle after an access |
| bus_err | output | 1 | Access hit no pin bit or an invalid range |
| pad_in | input | NPINS | Raw pad input levels |
| pad_oe | output | NPINS | Output enable per pin |
| pad_out | output | NPINS | Output level per pin |
| pad_pu | output | NPINS | Pull-up enable per pin |
| pad_pd | output | NPINS | Pull-down enable per pin |

## Verification
A write takes effect at the clock edge that samples it. The pad outputs are therefore compared on the falling edge that follows that edge. The response of an access is registered at the same edge, so rvalid, rdata and err are read at that same falling edge. A pad input change needs two edges to cross the synchronizer. For that reason the bench waits three idle cycles after any pad change before it reads the input range. The random traffic is checked against a bench model of the bank layout, and the directed cases cover the alias build, shared-word strobes and unmapped bits.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
   localparam int GPB_DW = 32;
   localparam int GPB_BW = GPB_DW / 8;

   typedef enum logic [2:0] {
      RNG_PEN  = 3'd0,
      RNG_PULL = 3'd1,
      RNG_DIR  = 3'd2,
      RNG_OUT  = 3'd3,
      RNG_IN   = 3'd4
   } gpb_rng_e;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpb_sync needs at least two stages");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/gpb_decode.sv
module gpb_decode
   import gpb_pkg::*;
#(
   parameter int  WIDX_W     = 2,
   parameter bit  PULL_ALIAS = 1'b0
) (
   input  logic [WIDX_W+2:0] addr,
   output gpb_rng_e          rng,
   output logic [WIDX_W-1:0] word,
   output logic              range_ok
);
   logic [2:0] code;

   assign code = addr[WIDX_W+2:WIDX_W];
   assign word = addr[WIDX_W-1:0];
   assign rng  = gpb_rng_e'(code);

   if (PULL_ALIAS) begin : g_alias
      assign range_ok = (code >= 3'd1) && (code <= 3'd4);
   end else begin : g_split
      assign range_ok = (code <= 3'd4);
   end
endmodule

// File: rtl/gpb_map.sv
module gpb_map #(
   parameter int NPINS  = 24,
   parameter int NBANKS = 3,
   parameter int WIDX_W = 2,
   parameter int BANK_FIRST [NBANKS] = '{default: 0},
   parameter int BANK_LAST  [NBANKS] = '{default: 0},
   parameter int FREG       [NBANKS] = '{default: 0},
   parameter int FBIT       [NBANKS] = '{default: 0}
) (
   input  logic [NPINS-1:0]  v,
   input  logic [WIDX_W-1:0] word,
   output logic [31:0]       rword,
   output logic              hit
);
   function automatic int bank_of(int p);
      int r = -1;
      for (int b = 0; b < NBANKS; b++)
         if (r < 0 && p >= BANK_FIRST[b] && p <= BANK_LAST[b]) r = b;
      return r;
   endfunction

   logic [31:0]      contrib [NPINS];
   logic [NPINS-1:0] phit;

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      localparam int BK = bank_of(p);
      if (BK >= 0) begin : g_on
         localparam int W = FREG[BK];
         localparam int B = FBIT[BK] + p - BANK_FIRST[BK];
         assign phit[p]    = (word == W[WIDX_W-1:0]);
         assign contrib[p] = phit[p] ? ({31'b0, v[p]} << B) : 32'b0;
      end else begin : g_off
         assign phit[p]    = 1'b0;
         assign contrib[p] = 32'b0;
      end
   end

   always_comb begin
      rword = '0;
      for (int p = 0; p < NPINS; p++) rword = rword | contrib[p];
      hit = |phit;
   end
endmodule

// File: rtl/gpb_field.sv
module gpb_field #(
   parameter int NPINS   = 24,
   parameter int NBANKS  = 3,
   parameter int WIDX_W  = 2,
   parameter bit RST_VAL = 1'b0,
   parameter int BANK_FIRST [NBANKS] = '{default: 0},
   parameter int BANK_LAST  [NBANKS] = '{default: 0},
   parameter int FREG       [NBANKS] = '{default: 0},
   parameter int FBIT       [NBANKS] = '{default: 0}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WIDX_W-1:0] word,
   input  logic [31:0]       wdata,
   input  logic [3:0]        wstrb,
   output logic [NPINS-1:0]  q,
   output logic [31:0]       rword,
   output logic              hit
);
   function automatic int bank_of(int p);
      int r = -1;
      for (int b = 0; b < NBANKS; b++)
         if (r < 0 && p >= BANK_FIRST[b] && p <= BANK_LAST[b]) r = b;
      return r;
   endfunction

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      localparam int BK = bank_of(p);
      if (BK >= 0) begin : g_on
         localparam int W = FREG[BK];
         localparam int B = FBIT[BK] + p - BANK_FIRST[BK];
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               r <= RST_VAL;
            else if (wr && word == W[WIDX_W-1:0] && wstrb[B/8])
               r <= wdata[B];
         end
         assign q[p] = r;
      end else begin : g_off
         assign q[p] = RST_VAL;
      end
   end

   gpb_map #(
      .NPINS(NPINS), .NBANKS(NBANKS), .WIDX_W(WIDX_W),
      .BANK_FIRST(BANK_FIRST), .BANK_LAST(BANK_LAST),
      .FREG(FREG), .FBIT(FBIT)
   ) u_map (
      .v(q), .word(word), .rword(rword), .hit(hit)
   );
endmodule

// File: rtl/gpb_regfile.sv
module gpb_regfile
   import gpb_pkg::*;
#(
   parameter int NPINS       = 24,
   parameter int NBANKS      = 3,
   parameter int NREGS       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit PULL_ALIAS  = 1'b0,
   parameter int BANK_FIRST [NBANKS] = '{0, 10, 16},
   parameter int BANK_LAST  [NBANKS] = '{9, 15, 23},
   parameter int PEN_REG    [NBANKS] = '{2, 2, 3},
   parameter int PEN_BIT    [NBANKS] = '{0, 16, 0},
   parameter int PULL_REG   [NBANKS] = '{0, 0, 1},
   parameter int PULL_BIT   [NBANKS] = '{0, 16, 0},
   parameter int DIR_REG    [NBANKS] = '{0, 0, 1},
   parameter int DIR_BIT    [NBANKS] = '{0, 10, 8},
   parameter int OUT_REG    [NBANKS] = '{0, 1, 1},
   parameter int OUT_BIT    [NBANKS] = '{0, 0, 8},
   parameter int IN_REG     [NBANKS] = '{0, 0, 0},
   parameter int IN_BIT     [NBANKS] = '{0, 10, 16},
   localparam int WIDX_W = (NREGS > 1) ? $clog2(NREGS) : 1,
   localparam int AW     = WIDX_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic             bus_re,
   input  logic [AW-1:0]    bus_addr,
   input  logic [31:0]      bus_wdata,
   input  logic [3:0]       bus_wstrb,
   output logic [31:0]      bus_rdata,
   output logic             bus_rvalid,
   output logic             bus_err,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_pu,
   output logic [NPINS-1:0] pad_pd
);
   // ---------------- elaboration-time parameter checks ----------------
   function automatic bit fld_bad(int regi, int biti, int b);
      return (regi < 0) || (regi >= NREGS) || (biti < 0) ||
             (biti + BANK_LAST[b] - BANK_FIRST[b] > GPB_DW - 1);
   endfunction

   if (NPINS < 1 || NBANKS < 1 || NREGS < 1) begin : g_bad_size
      $error("gpb_regfile: sizes must be positive");
   end
   for (genvar b = 0; b < NBANKS; b++) begin : g_chk
      if (BANK_LAST[b] < BANK_FIRST[b] || BANK_LAST[b] >= NPINS || BANK_FIRST[b] < 0) begin : g_bad_range
         $error("gpb_regfile: bank pin range out of bounds");
      end
      if (fld_bad(PEN_REG[b], PEN_BIT[b], b) || fld_bad(PULL_REG[b], PULL_BIT[b], b) ||
          fld_bad(DIR_REG[b], DIR_BIT[b], b) || fld_bad(OUT_REG[b], OUT_BIT[b], b) ||
          fld_bad(IN_REG[b], IN_BIT[b], b)) begin : g_bad_field
         $error("gpb_regfile: bank bit run leaves its register");
      end
   end

   // ---------------- address decode ----------------
   gpb_rng_e          rng;
   logic [WIDX_W-1:0] word;
   logic              range_ok;

   gpb_decode #(.WIDX_W(WIDX_W), .PULL_ALIAS(PULL_ALIAS)) u_dec (
      .addr(bus_addr), .rng(rng), .word(word), .range_ok(range_ok)
   );

   logic sel_pen, sel_pull, sel_dir, sel_out, sel_in;
   assign sel_pen  = range_ok && (PULL_ALIAS ? (rng == RNG_PULL) : (rng == RNG_PEN));
   assign sel_pull = range_ok && (rng == RNG_PULL);
   assign sel_dir  = range_ok && (rng == RNG_DIR);
   assign sel_out  = range_ok && (rng == RNG_OUT);
   assign sel_in   = range_ok && (rng == RNG_IN);

   // ---------------- storage fields ----------------
   logic [NPINS-1:0] pen_q, pull_q, dir_q, out_q, in_q;
   logic [31:0]      pen_rw, pull_rw, dir_rw, out_rw, in_rw;
   logic             pen_hit, pull_hit, dir_hit, out_hit, in_hit;

   gpb_field #(.NPINS(NPINS), .NBANKS(NBANKS), .WIDX_W(WIDX_W), .RST_VAL(1'b0),
      .BANK_FIRST(BANK_FIRST), .BANK_LAST(BANK_LAST), .FREG(PEN_REG), .FBIT(PEN_BIT)
   ) u_pen (
      .clk(clk), .rst_n(rst_n), .wr(bus_we && sel_pen), .word(word), .wdata(bus_wdata),
      .wstrb(bus_wstrb), .q(pen_q), .rword(pen_rw), .hit(pen_hit)
   );

   gpb_field #(.NPINS(NPINS), .NBANKS(NBANKS), .WIDX_W(WIDX_W), .RST_VAL(1'b0),
      .BANK_FIRST(BANK_FIRST), .BANK_LAST(BANK_LAST), .FREG(PULL_REG), .FBIT(PULL_BIT)
   ) u_pull (
      .clk(clk), .rst_n(rst_n), .wr(bus_we && sel_pull), .word(word), .wdata(bus_wdata),
      .wstrb(bus_wstrb), .q(pull_q), .rword(pull_rw), .hit(pull_hit)
   );

   gpb_field #(.NPINS(NPINS), .NBANKS(NBANKS), .WIDX_W(WIDX_W), .RST_VAL(1'b1),
      .BANK_FIRST(BANK_FIRST), .BANK_LAST(BANK_LAST), .FREG(DIR_REG), .FBIT(DIR_BIT)
   ) u_dir (
      .clk(clk), .rst_n(rst_n), .wr(bus_we && sel_dir), .word(word), .wdata(bus_wdata),
      .wstrb(bus_wstrb), .q(dir_q), .rword(dir_rw), .hit(dir_hit)
   );

   gpb_field #(.NPINS(NPINS), .NBANKS(NBANKS), .WIDX_W(WIDX_W), .RST_VAL(1'b0),
      .BANK_FIRST(BANK_FIRST), .BANK_LAST(BANK_LAST), .FREG(OUT_REG), .FBIT(OUT_BIT)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .wr(bus_we && sel_out), .word(word), .wdata(bus_wdata),
      .wstrb(bus_wstrb), .q(out_q), .rword(out_rw), .hit(out_hit)
   );

   // input path: synchronizer then read-only mapping
   gpb_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_q)
   );

   gpb_map #(.NPINS(NPINS), .NBANKS(NBANKS), .WIDX_W(WIDX_W),
      .BANK_FIRST(BANK_FIRST), .BANK_LAST(BANK_LAST), .FREG(IN_REG), .FBIT(IN_BIT)
   ) u_in (
      .v(in_q), .word(word), .rword(in_rw), .hit(in_hit)
   );

   // ---------------- response ----------------
   logic        hit_any, acc_err;
   logic [31:0] rd_word;

   always_comb begin
      hit_any = (sel_pen && pen_hit) || (sel_pull && pull_hit) || (sel_dir && dir_hit) ||
                (sel_out && out_hit) || (sel_in && in_hit);
      rd_word = (sel_pen  ? pen_rw  : 32'b0) | (sel_pull ? pull_rw : 32'b0) |
                (sel_dir  ? dir_rw  : 32'b0) | (sel_out  ? out_rw  : 32'b0) |
                (sel_in   ? in_rw   : 32'b0);
   end
   assign acc_err = !hit_any;

   logic        rvalid_q, err_q;
   logic [31:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         err_q    <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= bus_re || bus_we;
         err_q    <= (bus_re || bus_we) && acc_err;
         rdata_q  <= (bus_re && !bus_we && !acc_err) ? rd_word : 32'b0;
      end
   end

   assign bus_rvalid = rvalid_q;
   assign bus_err    = err_q;
   assign bus_rdata  = rdata_q;

   // ---------------- pad drive ----------------
   assign pad_oe  = ~dir_q;
   assign pad_out = out_q;
   assign pad_pu  = pen_q & pull_q;
   assign pad_pd  = pen_q & ~pull_q;

   // ---------------- assertions ----------------
   // R11
   rsp_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re || bus_we) |=> bus_rvalid);
   // R11
   no_rsp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_re || bus_we) |=> !bus_rvalid && !bus_err);
   // R9
   err_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_rdata == 32'b0));
   // R9
   err_write_keeps_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && acc_err) |=> $stable(pad_oe) && $stable(pad_out) && $stable(pad_pu) && $stable(pad_pd));
   // R7
   no_strobe_keeps_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_wstrb == 4'b0) |=> $stable(pad_oe) && $stable(pad_out) && $stable(pad_pu) && $stable(pad_pd));
   // R6
   in_write_keeps_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel_in) |=> $stable(pad_oe) && $stable(pad_out) && $stable(pad_pu) && $stable(pad_pd));
endmodule

// File: tb/sim_gpb_regfile.sv
`timescale 1ns/1ps
module sim_gpb_regfile;
   localparam int NP = 24;
   localparam int NB = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_wstrb = '0;
   logic [NP-1:0] pad_in = '0;

   logic [31:0] bus_rdata, u1_rdata;
   logic        bus_rvalid, bus_err, u1_rvalid, u1_err;
   logic [NP-1:0] pad_oe, pad_out, pad_pu, pad_pd;
   logic [NP-1:0] u1_oe, u1_out, u1_pu, u1_pd;

   always #5 clk = ~clk;

   gpb_regfile u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .bus_err(bus_err), .pad_in(pad_in), .pad_oe(pad_oe),
      .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd)
   );

   gpb_regfile #(.PULL_ALIAS(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(u1_rdata),
      .bus_rvalid(u1_rvalid), .bus_err(u1_err), .pad_in(pad_in), .pad_oe(u1_oe),
      .pad_out(u1_out), .pad_pu(u1_pu), .pad_pd(u1_pd)
   );

   // bank layout as specified (range order: pen, pull, dir, out, in)
   int bfirst [NB] = '{0, 10, 16};
   int blast  [NB] = '{9, 15, 23};
   int rreg [5][NB] = '{'{2, 2, 3}, '{0, 0, 1}, '{0, 0, 1}, '{0, 1, 1}, '{0, 0, 0}};
   int rbit [5][NB] = '{'{0, 16, 0}, '{0, 16, 0}, '{0, 10, 8}, '{0, 0, 8}, '{0, 10, 16}};

   bit mv [4][NP];
   logic [NP-1:0] pin_v = '0;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   function automatic int bk(int p);
      for (int b = 0; b < NB; b++) if (p >= bfirst[b] && p <= blast[b]) return b;
      return -1;
   endfunction

   function automatic bit mapped(int r, int w);
      if (r > 4) return 0;
      for (int p = 0; p < NP; p++) if (rreg[r][bk(p)] == w) return 1;
      return 0;
   endfunction

   function automatic logic [31:0] exp_rd(int r, int w);
      logic [31:0] v = '0;
      for (int p = 0; p < NP; p++) begin
         int b = bk(p);
         if (rreg[r][b] == w) v[rbit[r][b] + p - bfirst[b]] = (r == 4) ? pin_v[p] : mv[r][p];
      end
      return v;
   endfunction

   task automatic model_wr(int r, int w, logic [31:0] d, logic [3:0] s);
      if (r > 3) return;
      for (int p = 0; p < NP; p++) begin
         int b = bk(p);
         int pos = rbit[r][b] + p - bfirst[b];
         if (rreg[r][b] == w && s[pos/8]) mv[r][p] = d[pos];
      end
   endtask

   task automatic chk(input bit ok, input string rq, input logic [31:0] a, input logic [31:0] e);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, a, e);
      end
   endtask

   task automatic chk_pads();
      logic [NP-1:0] eoe, eo, epu, epd;
      for (int p = 0; p < NP; p++) begin
         eoe[p] = !mv[2][p];
         eo[p]  = mv[3][p];
         epu[p] = mv[0][p] && mv[1][p];
         epd[p] = mv[0][p] && !mv[1][p];
      end
      chk(pad_oe === eoe, "R3 pad_oe", 32'(pad_oe), 32'(eoe));
      chk(pad_out === eo, "R5 pad_out", 32'(pad_out), 32'(eo));
      chk(pad_pu === epu, "R4 pad_pu", 32'(pad_pu), 32'(epu));
      chk(pad_pd === epd, "R4 pad_pd", 32'(pad_pd), 32'(epd));
   endtask

   // one access; returns at the falling edge where the response is visible
   task automatic acc(input bit wr, input int r, input int w, input logic [31:0] d, input logic [3:0] s);
      bit e_err;
      logic [31:0] e_dat;
      @(negedge clk);
      bus_we = wr; bus_re = !wr;
      bus_addr = {r[2:0], w[1:0]};
      bus_wdata = d; bus_wstrb = s;
      e_err = !mapped(r, w);
      e_dat = (!wr && !e_err) ? exp_rd(r, w) : 32'b0;
      @(negedge clk);
      bus_we = 1'b0; bus_re = 1'b0;
      chk(bus_rvalid === 1'b1, "R11 rvalid", 32'(bus_rvalid), 32'd1);
      chk(bus_err === e_err, "R9 err", 32'(bus_err), 32'(e_err));
      chk(bus_rdata === e_dat, "R2 rdata", bus_rdata, e_dat);
      if (wr && !e_err) model_wr(r, w, d, s);
      chk_pads();
   endtask

   task automatic new_pads(input logic [NP-1:0] v);
      @(negedge clk);
      pad_in = v; pin_v = v;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      for (int p = 0; p < NP; p++) begin
         mv[0][p] = 0; mv[1][p] = 0; mv[2][p] = 1; mv[3][p] = 0;
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(pad_oe === '0 && pad_pu === '0 && pad_pd === '0 && pad_out === '0, "R1 reset pads",
          32'(pad_oe | pad_out | pad_pu | pad_pd), 32'd0);
      chk(bus_rvalid === 1'b0, "R11 idle rvalid", 32'(bus_rvalid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_rvalid === 1'b0 && bus_err === 1'b0, "R11 idle after reset", 32'(bus_rvalid), 32'd0);
      acc(0, 2, 0, 0, 0);                       // R1 dir word0 = all inputs
      chk(bus_rdata === 32'h0000FFFF, "R1 dir w0", bus_rdata, 32'h0000FFFF);
      acc(0, 3, 1, 0, 0);                       // R1 out word1 = 0
      chk(bus_rdata === 32'h0, "R1 out w1", bus_rdata, 32'h0);

      // R10 pull-enable aliased into the pull range (u1 only)
      acc(1, 1, 2, 32'h000003FF, 4'hF);
      chk(u1_err === 1'b0, "R10 alias write accepted", 32'(u1_err), 32'd0);
      acc(1, 1, 0, 32'h000000FF, 4'hF);
      chk(u1_pu === 24'h0000FF, "R10 alias pu", 32'(u1_pu), 32'h0000FF);
      chk(u1_pd === 24'h000300, "R10 alias pd", 32'(u1_pd), 32'h000300);
      acc(0, 0, 2, 0, 0);
      chk(u1_err === 1'b1, "R9 R10 alias range0 err", 32'(u1_err), 32'd1);

      // R7 strobe on a word shared by two banks
      acc(1, 2, 0, 32'h0, 4'b0001);
      chk(pad_oe[15:8] === 8'h00 && pad_oe[7:0] === 8'hFF, "R7 shared word strobe",
          32'(pad_oe), 32'h0000FF);
      acc(1, 2, 0, 32'hFFFFFFFF, 4'b0000);      // R7 no strobe, no change
      chk(pad_oe[7:0] === 8'hFF, "R7 zero strobe", 32'(pad_oe), 32'h0000FF);

      // R8 unmapped bits read 0
      acc(1, 3, 1, 32'hFFFFFFFF, 4'hF);
      acc(0, 3, 1, 0, 0);
      chk(bus_rdata === 32'h0000FF3F, "R8 unmapped read", bus_rdata, 32'h0000FF3F);

      // R6 input range synchronized and not writable
      new_pads(24'hA5C33C);
      acc(1, 4, 0, 32'hFFFFFFFF, 4'hF);
      acc(0, 4, 0, 0, 0);
      chk(bus_rdata === 32'h00A5C33C, "R6 input readback", bus_rdata, 32'h00A5C33C);

      // R9 invalid range codes and empty words
      acc(0, 6, 1, 0, 0);
      chk(bus_err === 1'b1, "R9 range 6", 32'(bus_err), 32'd1);
      acc(1, 0, 0, 32'hFFFFFFFF, 4'hF);
      chk(bus_err === 1'b1 && pad_pu === '0 && pad_pd === '0, "R9 empty pen word",
          32'(bus_err), 32'd1);

      // R4 bias table on pin 10
      acc(1, 0, 2, 32'h00010000, 4'b0100);
      chk(pad_pd[10] === 1'b1 && pad_pu[10] === 1'b0, "R4 pin10 pull-down", 32'(pad_pd[10]), 32'd1);
      acc(1, 1, 0, 32'h00010000, 4'b0100);
      chk(pad_pu[10] === 1'b1 && pad_pd[10] === 1'b0, "R4 pin10 pull-up", 32'(pad_pu[10]), 32'd1);
      acc(1, 0, 2, 32'h0, 4'b0100);
      chk(pad_pu[10] === 1'b0 && pad_pd[10] === 1'b0, "R4 pin10 bias off", 32'(pad_pu[10]), 32'd0);

      // random traffic against the model (R2 R3 R5 R7 R9)
      for (int i = 0; i < 600; i++) begin
         if (i % 40 == 0) new_pads(NP'($urandom));
         acc(1'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, 3),
             $urandom, 4'($urandom_range(0, 15)));
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule